// File: doc/BRIEF.md
# Narrowing Conversion Bounce Pre-Detector

This block looks at a floating-point operation before it executes and decides, from the opcode and the biased exponent of the double-precision source alone, whether the operation has to be handed to a software exception handler. Only a double-to-single narrowing conversion can leave the representable range. The check is deliberately pessimistic. Exponent bands near the top and bottom of the single-precision range are bounced even where the result would still fit, so no mantissa inspection or rounding is needed.

Move-type operations, widening conversion and integer-to-float conversion never bounce. The result appears on a registered flag together with a 2-bit reason code. The issue logic samples both one cycle after presenting the operation with its valid strobe.

Top module: `fp_bounce_detect`

## Requirements
- R1: Opcodes 0 (copy), 1 (absolute value) and 2 (negate) give bounce 0 and reason 00 for every exponent.
- R2: Opcode 3 (single-to-double widening) gives bounce 0 and reason 00 for every exponent.
- R3: Opcodes 5 (unsigned integer to float) and 6 (signed integer to float) give bounce 0 and reason 00 for every exponent.
- R4: Opcode 4 (double-to-single narrowing) with a biased exponent greater than 0x47F gives bounce 1 and reason 01 (overflow).
- R5: Opcode 4 with a biased exponent equal to 0x47F gives bounce 1 and reason 11 (special).
- R6: Opcode 4 with a biased exponent of 0x47D or 0x47E gives bounce 1 and reason 01 (overflow margin).
- R7: Opcode 4 with a biased exponent from 0x381 to 0x47C inclusive gives bounce 0 and reason 00.
- R8: Opcode 4 with a biased exponent of 0x380 or less gives bounce 1 and reason 10 (underflow).
- R9: Opcode 7 (unrecognised) gives bounce 0 and reason 00 for every exponent.
- R10: The outputs reflect the operation presented at the previous rising clock edge. A cycle with valid low yields bounce 0 and reason 00 whatever the opcode and exponent.
- R11: A synchronous active-high reset forces bounce 0 and reason 00 at the next clock edge, whatever the inputs are.
- R12: Bounce is 1 exactly when the reason code is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation present this cycle |
| op_i | input | 3 | Operation code (0 copy, 1 abs, 2 neg, 3 widen, 4 narrow, 5 uint-to-float, 6 sint-to-float, 7 unrecognised) |
| exp_i | input | 11 | Biased exponent of the double-precision source |
| bounce_o | output | 1 | Registered hand-off request |
| reason_o | output | 2 | Registered reason: 00 none, 01 overflow, 10 underflow, 11 special |

## Verification
The bench builds the block with its defaults: an 11-bit exponent, band limits 0x47F, 0x47D and 0x380, and the output register enabled. With only 2048 exponent values, the narrowing opcode can be swept exhaustively, so every band edge (0x37F/0x380/0x381, 0x47C/0x47D, 0x47E/0x47F/0x480) is hit rather than sampled. The other opcodes get random exponents. Directed cases cover the one-cycle latency, valid-low suppression and reset applied over a bouncing operation.

// File: rtl/fp_bounce_detect.sv
module fp_bounce_detect #(
  parameter int EXP_W = 11,
  parameter int OP_W  = 3,
  parameter logic [EXP_W-1:0] SPECIAL_EXP   = 11'h47F,
  parameter logic [EXP_W-1:0] OVF_MARGIN_LO = 11'h47D,
  parameter logic [EXP_W-1:0] UNF_TOP       = 11'h380,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [OP_W-1:0]  op_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             bounce_o,
  output logic [1:0]       reason_o
);

  localparam logic [OP_W-1:0] OP_NARROW = OP_W'(4);
  localparam logic [1:0] RSN_NONE = 2'b00;
  localparam logic [1:0] RSN_OVF  = 2'b01;
  localparam logic [1:0] RSN_UNF  = 2'b10;
  localparam logic [1:0] RSN_SPEC = 2'b11;

  wire is_narrow = valid_i && (op_i == OP_NARROW);
  wire at_spec   = (exp_i == SPECIAL_EXP);
  wire above     = (exp_i >  SPECIAL_EXP);
  wire margin    = (exp_i >= OVF_MARGIN_LO) && (exp_i < SPECIAL_EXP);
  wire under     = (exp_i <= UNF_TOP);

  logic [1:0] reason_d;
  always_comb begin
    reason_d = RSN_NONE;
    if (is_narrow) begin
      if (at_spec)              reason_d = RSN_SPEC;
      else if (above || margin) reason_d = RSN_OVF;
      else if (under)           reason_d = RSN_UNF;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [1:0] reason_q;
      always_ff @(posedge clk) begin
        if (rst) reason_q <= RSN_NONE;
        else     reason_q <= reason_d;
      end
      assign reason_o = reason_q;
      assign bounce_o = |reason_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst;
      assign reason_o = rst ? RSN_NONE : reason_d;
      assign bounce_o = |reason_o;
    end
  endgenerate

endmodule

module fp_bounce_detect_chk #(
  parameter int EXP_W = 11,
  parameter int OP_W  = 3,
  parameter logic [EXP_W-1:0] SPECIAL_EXP   = 11'h47F,
  parameter logic [EXP_W-1:0] OVF_MARGIN_LO = 11'h47D,
  parameter logic [EXP_W-1:0] UNF_TOP       = 11'h380,
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic [OP_W-1:0]  op_i,
  input logic [EXP_W-1:0] exp_i,
  input logic             bounce_o,
  input logic [1:0]       reason_o
);

  wire nar      = valid_i && (op_i == OP_W'(4));
  wire quiet_op = valid_i && (op_i != OP_W'(4));
  wire safe     = nar && (exp_i > UNF_TOP) && (exp_i < OVF_MARGIN_LO);
  wire spec     = nar && (exp_i == SPECIAL_EXP);
  wire low      = nar && (exp_i <= UNF_TOP);

  generate
    if (REG_OUT) begin : g_seq
      // R12
      flag_matches_reason_chk: assert property (@(posedge clk) disable iff (rst)
        bounce_o == (reason_o != 2'b00));
      // R10
      idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> (!bounce_o && reason_o == 2'b00));
      // R1
      other_ops_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_op |=> (!bounce_o && reason_o == 2'b00));
      // R7
      safe_band_chk: assert property (@(posedge clk) disable iff (rst)
        safe |=> !bounce_o);
      // R5
      special_exp_chk: assert property (@(posedge clk) disable iff (rst)
        spec |=> (bounce_o && reason_o == 2'b11));
      // R8
      underflow_chk: assert property (@(posedge clk) disable iff (rst)
        low |=> (bounce_o && reason_o == 2'b10));
      // R11
      reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!bounce_o && reason_o == 2'b00));
    end else begin : g_comb
      // R12
      flag_matches_reason_chk: assert property (@(posedge clk) disable iff (rst)
        bounce_o == (reason_o != 2'b00));
      // R1
      other_ops_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (quiet_op || !valid_i) |-> !bounce_o);
      // R7
      safe_band_chk: assert property (@(posedge clk) disable iff (rst)
        safe |-> !bounce_o);
      // R5
      special_exp_chk: assert property (@(posedge clk) disable iff (rst)
        spec |-> (reason_o == 2'b11));
      // R8
      underflow_chk: assert property (@(posedge clk) disable iff (rst)
        low |-> (reason_o == 2'b10));
    end
  endgenerate

endmodule

bind fp_bounce_detect fp_bounce_detect_chk #(
  .EXP_W(EXP_W), .OP_W(OP_W), .SPECIAL_EXP(SPECIAL_EXP),
  .OVF_MARGIN_LO(OVF_MARGIN_LO), .UNF_TOP(UNF_TOP), .REG_OUT(REG_OUT)
) chk (
  .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .exp_i(exp_i),
  .bounce_o(bounce_o), .reason_o(reason_o)
);

// File: tb/tb_fp_bounce_detect.sv
module tb_fp_bounce_detect;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_i = 1'b0;
  logic [2:0]  op_i = 3'd0;
  logic [10:0] exp_i = 11'd0;
  logic        bounce_o;
  logic [1:0]  reason_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fp_bounce_detect dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .exp_i(exp_i),
    .bounce_o(bounce_o), .reason_o(reason_o)
  );

  localparam int NV = 16;
  localparam logic [15:0] VEC [NV] = '{
    {3'd4, 11'h47F, 2'd3}, {3'd4, 11'h480, 2'd1}, {3'd4, 11'h7FF, 2'd1},
    {3'd4, 11'h47E, 2'd1}, {3'd4, 11'h47D, 2'd1}, {3'd4, 11'h47C, 2'd0},
    {3'd4, 11'h3FF, 2'd0}, {3'd4, 11'h381, 2'd0}, {3'd4, 11'h380, 2'd2},
    {3'd4, 11'h000, 2'd2}, {3'd0, 11'h7FF, 2'd0}, {3'd1, 11'h000, 2'd0},
    {3'd2, 11'h47F, 2'd0}, {3'd3, 11'h500, 2'd0}, {3'd5, 11'h47F, 2'd0},
    {3'd7, 11'h000, 2'd0}
  };

  function automatic logic [1:0] model(input logic [2:0] op, input logic [10:0] e);
    if (op != 3'd4)      return 2'd0;
    if (e == 11'h47F)    return 2'd3;
    if (e > 11'h47C)     return 2'd1;
    if (e <= 11'h380)    return 2'd2;
    return 2'd0;
  endfunction

  function automatic string tag(input logic [2:0] op, input logic [10:0] e);
    if (op <= 3'd2) return "R1";
    if (op == 3'd3) return "R2";
    if (op == 3'd5 || op == 3'd6) return "R3";
    if (op == 3'd7) return "R9";
    if (e > 11'h47F) return "R4";
    if (e == 11'h47F) return "R5";
    if (e >= 11'h47D) return "R6";
    if (e > 11'h380) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [1:0] exp_r);
    logic exp_b;
    exp_b = (exp_r != 2'd0);
    checks++;
    if (bounce_o !== exp_b || reason_o !== exp_r) begin
      errors++;
      $display("FAIL %s got bounce=%0b reason=%0d expected bounce=%0b reason=%0d",
               req, bounce_o, reason_o, exp_b, exp_r);
    end
  endtask

  task automatic apply(input logic v, input logic [2:0] op, input logic [10:0] e);
    @(negedge clk);
    valid_i = v; op_i = op; exp_i = e;
    @(negedge clk);
    check(v ? tag(op, e) : "R10", v ? model(op, e) : 2'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset with a bouncing operation present
    valid_i = 1'b1; op_i = 3'd4; exp_i = 11'h7FF;
    repeat (3) @(negedge clk);
    check("R11", 2'd0);
    rst = 1'b0;
    valid_i = 1'b0;

    for (int i = 0; i < NV; i++) apply(1'b1, VEC[i][15:13], VEC[i][12:2]);
    for (int i = 0; i < NV; i++) begin
      checks++;
      if (model(VEC[i][15:13], VEC[i][12:2]) !== VEC[i][1:0]) begin
        errors++;
        $display("FAIL %s table entry %0d got %0d expected %0d",
                 tag(VEC[i][15:13], VEC[i][12:2]), i,
                 model(VEC[i][15:13], VEC[i][12:2]), VEC[i][1:0]);
      end
    end

    for (int e = 0; e < 2048; e++) apply(1'b1, 3'd4, 11'(e));

    for (int o = 0; o < 8; o++) begin
      if (o == 4) continue;
      for (int k = 0; k < 40; k++) apply(1'b1, 3'(o), 11'($urandom));
    end

    // R10: valid low suppresses a would-be bounce
    apply(1'b0, 3'd4, 11'h500);
    apply(1'b0, 3'd4, 11'h000);

    // R10: one-cycle latency, output unchanged before the edge
    @(negedge clk);
    valid_i = 1'b1; op_i = 3'd4; exp_i = 11'h47F;
    #1 check("R10", 2'd0);
    @(negedge clk);
    check("R5", 2'd3);
    valid_i = 1'b1; op_i = 3'd0; exp_i = 11'h47F;
    @(negedge clk);
    check("R1", 2'd0);

    // R11: reset mid-run over an underflow operation
    valid_i = 1'b1; op_i = 3'd4; exp_i = 11'h010;
    @(negedge clk);
    check("R8", 2'd2);
    rst = 1'b1;
    @(negedge clk);
    check("R11", 2'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R8", 2'd2);
    valid_i = 1'b0;
    @(negedge clk);
    check("R10", 2'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule